// File: doc/BRIEF.md
# Interrupt Distribution Unit

This block takes a set of shared interrupt inputs and steers each one onto per-core interrupt lines. Every shared interrupt has three pieces of state: a mask bit, a destination core mask with one bit per core, and a mode. The mode chooses how the interrupt is distributed and whether it is level or edge triggered. Distribution is either round-robin load balancing across the destination cores or fixed delivery to the destination. All of this state is written through a single command port that carries an opcode, the index of the shared interrupt and a data word. A separate command switches the whole unit on.

Each core sees one output line per shared interrupt. Line `core_irq[c*NUM_IRQS + i]` carries shared interrupt `i` to core `c`, so a core's lines for interrupts 0, 1, 2... map in order onto consecutive core interrupt numbers. In round-robin mode a pointer kept per interrupt hands each new assertion to the next core in the destination mask. This spreads the work from one busy source over several cores. Outputs are registered and follow the inputs one clock later. All inputs are synchronous to `clk`.

Top module: `irq_distrib`

## Requirements
- R1: After reset every interrupt is masked, every destination mask is zero and the unit is disabled, so no output rises even with inputs high and the enable command issued.
- R2: No output rises until the enable command (opcode 1) has been issued. After it, a configured interrupt is forwarded, with shared interrupt i to core c appearing on `core_irq[c*NUM_IRQS+i]`.
- R3: Opcode 2 writes the mask bit of interrupt `cmd_idx` from `cmd_data[0]` (1 masks, 0 unmasks). Opcode 3 writes its destination mask from `cmd_data[NUM_CORES-1:0]`. Opcode 4 writes its mode. Any other opcode changes nothing.
- R4: In the mode word, `cmd_data[1:0]` is the distribution code and `cmd_data[4]` set selects level triggering. Code 0 selects round-robin. Code 2 and every other nonzero code select fixed delivery.
- R5: Fixed delivery with level triggering drives only the lowest-numbered core set in the destination mask. That line follows the input level one clock later.
- R6: Fixed delivery with edge triggering gives a one-clock pulse on every core in the destination mask, one clock after the input rises.
- R7: In round-robin mode each rising input picks the next set core in the destination mask after the core picked last, wrapping around. The first pick after reset is the lowest set core.
- R8: In round-robin level mode the picked core's line stays high while the input stays high and drops one clock after the input drops. In round-robin edge mode the picked line pulses for one clock.
- R9: A masked interrupt, or one with an all-zero destination mask, drives no output and does not advance its round-robin pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_idx | input | $clog2(NUM_IRQS) | Index of the shared interrupt addressed |
| cmd_data | input | max(NUM_CORES,5) | Command data word |
| irq_in | input | NUM_IRQS | Shared interrupt inputs |
| core_irq | output | NUM_CORES*NUM_IRQS | Per-core lines, bit c*NUM_IRQS+i for interrupt i at core c |

## Verification
The assertions assume that `irq_in` is synchronous to `clk` and that the configuration of an interrupt is not rewritten while its input is high. Under that assumption a held round-robin grant always belongs to the current destination mask. The bench drives the inputs and commands on falling edges. It returns every input low before it reconfigures the matching interrupt, and it issues commands only in cycles where no input edge is being checked.

// File: rtl/irq_distrib.sv
module irq_distrib #(
  parameter int NUM_CORES = 4,
  parameter int NUM_IRQS  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [2:0]                    cmd_op,
  input  logic [(NUM_IRQS>1 ? $clog2(NUM_IRQS) : 1)-1:0] cmd_idx,
  input  logic [(NUM_CORES>5 ? NUM_CORES : 5)-1:0]       cmd_data,
  input  logic [NUM_IRQS-1:0]           irq_in,
  output logic [NUM_CORES*NUM_IRQS-1:0] core_irq
);
  localparam int CW = NUM_CORES > 1 ? $clog2(NUM_CORES) : 1;
  localparam logic [2:0] OP_ENABLE = 3'd1;
  localparam logic [2:0] OP_MASK   = 3'd2;
  localparam logic [2:0] OP_DEST   = 3'd3;
  localparam logic [2:0] OP_MODE   = 3'd4;

  logic                          en;
  logic [NUM_IRQS-1:0]           msk, lvl, rr, held, irq_q;
  logic [NUM_IRQS-1:0][NUM_CORES-1:0] dest, col_d, col_q;
  logic [NUM_IRQS-1:0][CW-1:0]   last, pick;
  logic [NUM_IRQS-1:0]           act, rise;

  function automatic logic [CW-1:0] rr_next(input logic [NUM_CORES-1:0] m,
                                            input logic [CW-1:0] from);
    logic [CW-1:0] r;
    logic found;
    int idx;
    r = from;
    found = 1'b0;
    for (int k = 1; k <= NUM_CORES; k++) begin
      idx = int'(from) + k;
      if (idx >= NUM_CORES) idx -= NUM_CORES;
      if (!found && m[idx]) begin
        r = CW'(idx);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [NUM_CORES-1:0] onehot(input logic [CW-1:0] c);
    return NUM_CORES'(1) << c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      msk  <= '1;
      dest <= '0;
      lvl  <= '0;
      rr   <= '0;
    end else if (cmd_valid) begin
      if (cmd_op == OP_ENABLE) en <= 1'b1;
      if (int'(cmd_idx) < NUM_IRQS) begin
        case (cmd_op)
          OP_MASK: msk[cmd_idx]  <= cmd_data[0];
          OP_DEST: dest[cmd_idx] <= cmd_data[NUM_CORES-1:0];
          OP_MODE: begin
            rr[cmd_idx]  <= (cmd_data[1:0] == 2'd0);
            lvl[cmd_idx] <= cmd_data[4];
          end
          default: ;
        endcase
      end
    end
  end

  for (genvar i = 0; i < NUM_IRQS; i++) begin : g_irq
    assign act[i]  = en && !msk[i] && (dest[i] != '0);
    assign rise[i] = irq_in[i] && !irq_q[i];
    assign pick[i] = rr_next(dest[i], last[i]);
    assign col_d[i] =
      !act[i] ? '0 :
      rr[i]   ? (rise[i] ? onehot(pick[i]) :
                 (lvl[i] && held[i] && irq_in[i]) ? onehot(last[i]) : '0) :
      lvl[i]  ? (irq_in[i] ? (dest[i] & (~dest[i] + NUM_CORES'(1))) : '0) :
                (rise[i] ? dest[i] : '0);

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
      assign core_irq[c*NUM_IRQS + i] = col_q[i][c];
    end

    // R9
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msk[i] || dest[i] == '0) |=> col_q[i] == '0);
    // R5
    single_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rr[i] || lvl[i]) |=> $onehot0(col_q[i]));
    // R8
    input_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_in[i] |=> col_q[i] == '0);
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !act[i] |=> last[i] == $past(last[i]));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= '0;
      held  <= '0;
      col_q <= '0;
      for (int i = 0; i < NUM_IRQS; i++) last[i] <= CW'(NUM_CORES - 1);
    end else begin
      irq_q <= irq_in;
      col_q <= col_d;
      for (int i = 0; i < NUM_IRQS; i++) begin
        if (act[i] && rr[i] && rise[i]) begin
          last[i] <= pick[i];
          held[i] <= 1'b1;
        end else if (!irq_in[i]) begin
          held[i] <= 1'b0;
        end
      end
    end
  end

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> core_irq == '0);
endmodule

// File: tb/irq_distrib_tb.sv
module irq_distrib_tb;
  localparam int NC = 4;
  localparam int NI = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [1:0] cmd_idx = '0;
  logic [4:0] cmd_data = '0;
  logic [NI-1:0] irq_in = '0;
  logic [NC*NI-1:0] core_irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_distrib #(.NUM_CORES(NC), .NUM_IRQS(NI)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_idx(cmd_idx), .cmd_data(cmd_data), .irq_in(irq_in), .core_irq(core_irq)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [15:0] col(int i);
    logic [15:0] r = '0;
    for (int c = 0; c < NC; c++) r[c] = core_irq[c*NI + i];
    return r;
  endfunction

  task automatic cmd(logic [2:0] op, int idx, logic [4:0] data);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = 2'(idx); cmd_data = data;
    tick();
    cmd_valid = 1'b0;
  endtask

  task automatic do_reset();
    irq_in = '0;
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic setup(int idx, logic [4:0] dst, logic [4:0] mode);
    cmd(3'd3, idx, dst);
    cmd(3'd4, idx, mode);
    cmd(3'd2, idx, 5'd0);
  endtask

  task automatic t_reset();
    do_reset();
    irq_in = '1;
    tick(); tick();
    chk("R1 reset outputs", core_irq, 16'h0);
    cmd(3'd1, 0, 5'd0);
    tick(); tick();
    chk("R1 masked after enable", core_irq, 16'h0);
    irq_in = '0;
    tick();
  endtask

  task automatic t_enable();
    do_reset();
    setup(0, 5'b00010, 5'h12);
    irq_in[0] = 1'b1;
    tick(); tick();
    chk("R2 before enable", core_irq, 16'h0);
    cmd(3'd1, 0, 5'd0);
    tick();
    chk("R2 after enable", col(0), 16'h2);
    chk("R2 line position", core_irq, 16'h1 << (1*NI + 0));
    irq_in[0] = 1'b0;
    tick();
  endtask

  task automatic t_fixed_level();
    setup(1, 5'b01100, 5'h12);
    irq_in[1] = 1'b1;
    tick();
    chk("R5 lowest core", col(1), 16'h4);
    tick(); tick();
    chk("R5 follows level", col(1), 16'h4);
    irq_in[1] = 1'b0;
    tick();
    chk("R5 drops", col(1), 16'h0);
    cmd(3'd4, 1, 5'h13);
    irq_in[1] = 1'b1;
    tick();
    chk("R4 code 3 is fixed", col(1), 16'h4);
    irq_in[1] = 1'b0;
    tick();
    cmd(3'd7, 1, 5'd1);
    irq_in[1] = 1'b1;
    tick();
    chk("R3 unknown opcode ignored", col(1), 16'h4);
    irq_in[1] = 1'b0;
    tick();
  endtask

  task automatic t_fixed_edge();
    setup(2, 5'b00101, 5'h02);
    irq_in[2] = 1'b1;
    tick();
    chk("R6 pulse to mask", col(2), 16'h5);
    tick();
    chk("R6 pulse ends", col(2), 16'h0);
    irq_in[2] = 1'b0;
    tick();
  endtask

  task automatic rr_pulse(int idx, logic [15:0] exp, string req);
    irq_in[idx] = 1'b1;
    tick();
    chk(req, col(idx), exp);
    irq_in[idx] = 1'b0;
    tick();
  endtask

  task automatic t_rr_level();
    setup(3, 5'b01011, 5'h10);
    irq_in[3] = 1'b1;
    tick();
    chk("R7 first pick lowest", col(3), 16'h1);
    tick();
    chk("R8 level hold", col(3), 16'h1);
    irq_in[3] = 1'b0;
    tick();
    chk("R8 level drop", col(3), 16'h0);
    rr_pulse(3, 16'h2, "R7 second pick");
    rr_pulse(3, 16'h8, "R7 skip unset core");
    rr_pulse(3, 16'h1, "R7 wrap");
  endtask

  task automatic t_rr_edge();
    setup(0, 5'b00110, 5'h00);
    irq_in[0] = 1'b1;
    tick();
    chk("R8 edge pick", col(0), 16'h2);
    tick();
    chk("R8 edge one cycle", col(0), 16'h0);
    irq_in[0] = 1'b0;
    tick();
    rr_pulse(0, 16'h4, "R7 edge rotate");
  endtask

  task automatic t_mask();
    cmd(3'd2, 3, 5'd1);
    rr_pulse(3, 16'h0, "R9 masked quiet");
    rr_pulse(3, 16'h0, "R9 masked quiet again");
    cmd(3'd2, 3, 5'd0);
    rr_pulse(3, 16'h2, "R9 pointer held");
    cmd(3'd3, 2, 5'd0);
    rr_pulse(2, 16'h0, "R9 empty dest");
  endtask

  initial begin
    #(2_000_000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_enable();
    t_fixed_level();
    t_fixed_edge();
    t_rr_level();
    t_rr_edge();
    t_mask();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule